// File: doc/BRIEF.md
# Dual-Mode Debug Bit Shifter

This block drives a serial debug port bit by bit. Software (or a transport layer above it) loads a bit count from 1 to 32, a mode-select word and a data word, then pulses a start strobe. The block then generates a slow debug clock and presents one bit of each word per clock period, least significant bit first. On every rising debug-clock edge it samples the serial return line into a result word. It has no knowledge of any protocol: sequences longer than 32 bits are split by the caller into successive operations.

For a boundary-scan port, the three serial outputs connect to the mode-select, data-in and clock pins, and the return line connects to data-out. For a two-wire serial debug port, the mode-select stream becomes the data line output, and the return input samples that same data line. Only the wiring changes. The tristate pad and the line turnaround belong outside the block.

The control and status pins are plain levels and strobes. There is no back-pressure. A start strobe is honoured only while the block is idle. The operands are captured on the clock edge that accepts the start.

Top module: `dbs_shifter`

## Requirements
- R1: After reset, `tck_o`, `tms_o`, `tdi_o`, `busy_o` and `done_o` are 0 and `tdo_word_o` reads 0.
- R2: A `start_i` high on an edge while `busy_o` is 0 is accepted. From the next cycle `busy_o` is 1 and `done_o` is 0. On that same edge the block captures `len_i` (bit count minus one: 0 means 1 bit, 31 means 32 bits), both words and `half_div_i`.
- R3: During debug-clock period k (k counted from 0), `tms_o` equals bit k of the captured mode word and `tdi_o` equals bit k of the captured data word. These outputs change only at the start of an operation or on the cycle where `tck_o` falls, so they are stable across each rising edge.
- R4: `tdo_i` is sampled on the system edge that raises `tck_o`. The sample from period k lands in bit k of `tdo_word_o`.
- R5: Bits of `tdo_word_o` at or above the programmed bit count read 0 when the operation ends.
- R6: Every count from 1 to 32 bits works. `busy_o` stays high for exactly 2·H·N system cycles, where N is the bit count and H the half-period, and then `done_o` rises.
- R7: Each debug-clock period is low for H system cycles and then high for H system cycles. H is `half_div_i`, and a value of 0 is treated as 1, so the minimum ratio is 2.
- R8: `tck_o` is low whenever `busy_o` is 0, so every operation ends with the clock low.
- R9: A `start_i` while `busy_o` is 1 is ignored. The running operation keeps its operands, its length and its timing.
- R10: `done_o` and `tdo_word_o` hold their values until the next accepted start, whatever `tdo_i` does meanwhile.
- R11: With `tdo_i` wired to `tms_o` (two-wire loopback), the result word equals the mode word masked to the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, honoured only when idle |
| len_i | input | 5 | Bit count minus one |
| half_div_i | input | 8 | Debug-clock half-period in system cycles (0 acts as 1) |
| tms_word_i | input | 32 | Mode-select word, bit 0 shifted first |
| tdi_word_i | input | 32 | Data word, bit 0 shifted first |
| tdo_word_o | output | 32 | Captured return bits, first sample at bit 0 |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Last operation finished; held until next start |
| tck_o | output | 1 | Debug clock, idles low |
| tms_o | output | 1 | Mode-select stream (two-wire data out) |
| tdi_o | output | 1 | Data stream |
| tdo_i | input | 1 | Return line (two-wire data in) |

## Verification
A wrong bit index or a wrong shift-register state shows up within one debug-clock period. Either `tms_o`/`tdi_o` carry the wrong bit at a rising edge, or a return sample lands in the wrong position of `tdo_word_o`. A fault in the divider counter changes the measured high-phase length, and therefore the total busy time, by the end of the first period. A length or completion fault moves the fall of `busy_o` or leaves stray bits in the result. A gating fault on the start strobe restarts the shift midway, which corrupts both the timing and the result of the running operation.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;
endpackage

// File: rtl/dbs_clkgen.sv
module dbs_clkgen
  import dbs_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_div_i,
  output logic             tck_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] half_q;
  logic [DIV_W-1:0] cnt_q;
  phase_e           ph_q;
  logic             tick;

  assign tick   = run_i && !restart_i && (cnt_q == half_q - DIV_W'(1));
  assign rise_o = tick && (ph_q == PH_LOW);
  assign fall_o = tick && (ph_q == PH_HIGH);
  assign tck_o  = (ph_q == PH_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= DIV_W'(1);
      cnt_q  <= '0;
      ph_q   <= PH_LOW;
    end else if (restart_i) begin
      half_q <= (half_div_i == '0) ? DIV_W'(1) : half_div_i;
      cnt_q  <= '0;
      ph_q   <= PH_LOW;
    end else if (!run_i) begin
      cnt_q <= '0;
      ph_q  <= PH_LOW;
    end else if (tick) begin
      cnt_q <= '0;
      ph_q  <= (ph_q == PH_LOW) ? PH_HIGH : PH_LOW;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  // R7: the half-period counter never passes the programmed limit
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < half_q);
  // R8: the clock goes low and stays low once the run is over
  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !restart_i) |=> !tck_o);
  // R7: the divider is never zero
  p_half_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    half_q != '0);
endmodule

// File: rtl/dbs_bitseq.sv
module dbs_bitseq #(
  parameter int WORD_W = 32,
  localparam int LEN_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [WORD_W-1:0] tms_word_i,
  input  logic [WORD_W-1:0] tdi_word_i,
  input  logic              fall_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [LEN_W-1:0]  idx_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              tms_o,
  output logic              tdi_o
);
  logic              busy_q, done_q;
  logic [LEN_W-1:0]  idx_q, len_q;
  logic [WORD_W-1:0] tms_sh, tdi_sh;
  logic              last_bit;

  assign accept_o = start_i && !busy_q;
  assign last_bit = (idx_q == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
      tms_sh <= '0;
      tdi_sh <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      idx_q  <= '0;
      len_q  <= len_i;
      tms_sh <= tms_word_i;
      tdi_sh <= tdi_word_i;
    end else if (busy_q && fall_i) begin
      if (last_bit) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        idx_q  <= idx_q + LEN_W'(1);
        tms_sh <= {1'b0, tms_sh[WORD_W-1:1]};
        tdi_sh <= {1'b0, tdi_sh[WORD_W-1:1]};
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign idx_o  = idx_q;
  assign len_o  = len_q;
  assign tms_o  = tms_sh[0];
  assign tdi_o  = tdi_sh[0];

  // R10: done and busy are never both set
  p_done_busy_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));
  // R10: done holds until a start arrives
  p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_i) |=> done_q);
  // R9: a start while busy leaves the captured length alone
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_q) |=> $stable(len_q));
  // R3: the serial outputs move only on a falling debug edge or a start
  p_out_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_i && !accept_o) |=> ($stable(tms_o) && $stable(tdi_o)));
  // R6: the bit index never passes the programmed length
  p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q <= len_q));
endmodule

// File: rtl/dbs_capture.sv
module dbs_capture #(
  parameter int WORD_W = 32,
  localparam int LEN_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              rise_i,
  input  logic [LEN_W-1:0]  idx_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              done_i,
  input  logic              tdo_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] cap_q;
  logic [WORD_W-1:0] upper;

  for (genvar k = 0; k < WORD_W; k++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    cap_q[k] <= 1'b0;
      else if (clear_i)                              cap_q[k] <= 1'b0;
      else if (rise_i && (idx_i == LEN_W'(k)))       cap_q[k] <= tdo_i;
    end
    assign upper[k] = (LEN_W'(k) > len_i);
  end

  assign word_o = cap_q;

  // R5: nothing above the programmed length is ever captured
  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> ((cap_q & upper) == '0));
  // R10: the result is frozen while no operation runs
  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !clear_i) |=> $stable(cap_q));
endmodule

// File: rtl/dbs_shifter.sv
module dbs_shifter #(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic [WORD_W-1:0] tms_word_i,
  input  logic [WORD_W-1:0] tdi_word_i,
  output logic [WORD_W-1:0] tdo_word_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o,
  input  logic              tdo_i
);
  logic             accept, rise, fall, busy, done;
  logic [LEN_W-1:0] idx, len_q;

  dbs_bitseq #(.WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .tms_word_i(tms_word_i), .tdi_word_i(tdi_word_i), .fall_i(fall),
    .accept_o(accept), .busy_o(busy), .done_o(done), .idx_o(idx),
    .len_o(len_q), .tms_o(tms_o), .tdi_o(tdi_o)
  );

  dbs_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .restart_i(accept), .run_i(busy),
    .half_div_i(half_div_i), .tck_o(tck_o), .rise_o(rise), .fall_o(fall)
  );

  dbs_capture #(.WORD_W(WORD_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .clear_i(accept), .rise_i(rise), .idx_i(idx),
    .len_i(len_q), .done_i(done), .tdo_i(tdo_i), .word_o(tdo_word_o)
  );

  assign busy_o = busy;
  assign done_o = done;

  // R8: the debug clock is low whenever the block is idle
  p_idle_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck_o);
  // R4: a capture only happens during a running operation
  p_rise_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> busy);
endmodule

// File: tb/dbs_shifter_tb.sv
module dbs_shifter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  len_i = '0;
  logic [7:0]  half_div_i = '0;
  logic [31:0] tms_word_i = '0, tdi_word_i = '0;
  logic [31:0] tdo_word_o;
  logic        busy_o, done_o, tck_o, tms_o, tdi_o, tdo_i;

  logic [31:0] pat = '0;
  bit          loop_en = 1'b0;
  int          rcnt = 0;
  int          nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  assign tdo_i = loop_en ? tms_o : ((rcnt < 32) ? pat[rcnt] : 1'b0);

  dbs_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .half_div_i(half_div_i), .tms_word_i(tms_word_i), .tdi_word_i(tdi_word_i),
    .tdo_word_o(tdo_word_o), .busy_o(busy_o), .done_o(done_o), .tck_o(tck_o),
    .tms_o(tms_o), .tdi_o(tdi_o), .tdo_i(tdo_i)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] len_mask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  task automatic run_op(input int nbits, input logic [31:0] tms, input logic [31:0] tdi,
                        input logic [31:0] p, input int half, input bit lp, input bit inject);
    int h, cyc, hi, bad3, bad7;
    logic prev;
    logic [31:0] expw, held;
    h = (half == 0) ? 1 : half;
    pat = p; loop_en = lp; rcnt = 0;
    len_i = 5'(nbits - 1); half_div_i = 8'(half);
    tms_word_i = tms; tdi_word_i = tdi;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && !done_o, "R2 busy after start", {busy_o, done_o}, 2'b10);
    cyc = 0; hi = 0; bad3 = 0; bad7 = 0; prev = 1'b0;
    while (busy_o && cyc < 20000) begin
      if (tck_o && !prev) begin
        if (tms_o !== tms[rcnt] || tdi_o !== tdi[rcnt]) bad3++;
        rcnt++;
      end
      if (tck_o) hi++;
      if (!tck_o && prev) begin
        if (hi != h) bad7++;
        hi = 0;
      end
      if (inject && cyc == 3) begin
        start_i = 1'b1; len_i = 5'd0; half_div_i = 8'd9;
        tms_word_i = ~tms; tdi_word_i = ~tdi;
      end else begin
        start_i = 1'b0;
      end
      prev = tck_o; cyc++;
      @(negedge clk);
    end
    start_i = 1'b0;
    if (prev && hi != h) bad7++;
    chk(bad3 == 0, "R3 serial bits per period", bad3, 0);
    chk(bad7 == 0 && rcnt == nbits, "R7 high phase length / period count", {bad7[31:0], rcnt[31:0]}, {32'd0, nbits[31:0]});
    chk(cyc == 2 * h * nbits, inject ? "R9 duration with ignored start" : "R6 busy duration", cyc, 2 * h * nbits);
    chk(done_o && !tck_o, "R8 clock low at end / done set", {done_o, tck_o}, 2'b10);
    expw = lp ? (tms & len_mask(nbits)) : (p & len_mask(nbits));
    chk(tdo_word_o == expw, lp ? "R11 loopback result" : (inject ? "R9 result with ignored start" : "R4 captured word"),
        tdo_word_o, expw);
    chk((tdo_word_o & ~len_mask(nbits)) == 0, "R5 upper bits zero", tdo_word_o & ~len_mask(nbits), 0);
    held = tdo_word_o;
    pat = ~pat; rcnt = 0;
    repeat (4) begin
      @(negedge clk);
      if (!done_o || tdo_word_o != held || tck_o) bad3 = 99;
    end
    chk(bad3 != 99, "R10 done and result held", tdo_word_o, held);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(tck_o == 0 && tms_o == 0 && tdi_o == 0 && busy_o == 0 && done_o == 0 && tdo_word_o == 0,
        "R1 reset state", {tck_o, tms_o, tdi_o, busy_o, done_o, tdo_word_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(1, 32'h1, 32'h0, 32'h1, 1, 1'b0, 1'b0);
    run_op(2, 32'h2, 32'h1, 32'h2, 0, 1'b0, 1'b0);
    run_op(32, 32'hA5C3_0F96, 32'h1234_5678, 32'hDEAD_BEEF, 2, 1'b0, 1'b0);
    run_op(13, 32'h0000_1A5B, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5, 1'b0, 1'b0);
    run_op(32, 32'h8000_0001, 32'h0, 32'h0, 1, 1'b1, 1'b0);
    run_op(12, 32'h0000_08A5, 32'h0, 32'h0, 3, 1'b1, 1'b0);
    run_op(8, 32'h0000_00C3, 32'h55, 32'h0000_00F0, 2, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) begin
      int n, hv;
      n  = 1 + int'($urandom_range(31, 0));
      hv = int'($urandom_range(4, 0));
      run_op(n, $urandom, $urandom, $urandom, hv, 1'($urandom_range(1, 0)), 1'b0);
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule